// File: doc/BRIEF.md
# Cascade Start Synchroniser

This block lets several identical physical-layer devices wait for one another and then begin work on the same clock. Each device drives a shared open-drain ready line. It holds that line low until two things are true: its cascade-mode enable is set, and its receive path has reported the J-K start symbol pair. The ready lines of all devices are wired together, so the shared line only goes high once every device has let go. That shared line comes back into each device as its start input.

A rising edge on the synchronised start input, seen while the device has already let go of the line, produces a one-cycle start pulse and a start level. The start level stays high for as long as cascade mode stays on. Clearing cascade mode pulls the ready line low again at once and returns the device to idle. It also discards the captured symbol pair, so a fresh pair is needed before the device can release again. A device that does not use cascade mode has its start input tied low, and that input then does nothing.

Top module: `cascade_sync`

## Requirements
- R1: While reset is held and directly after it, `readyOe` is 1 (line pulled low), `startPulse` is 0 and `startLevel` is 0.
- R2: While `cascadeEn` is 0, `readyOe` stays 1 whatever `jkPairSeen` does, and a symbol-pair pulse seen while disabled is not remembered.
- R3: With `cascadeEn` held at 1, a `jkPairSeen` pulse sampled at clock edge N makes `readyOe` fall to 0 after edge N+1. Without such a pulse, `readyOe` stays 1.
- R4: The captured symbol pair is sticky: one single-cycle pulse is enough for release. With the start input held low, the device never starts.
- R5: A 0-to-1 change of `startIn` sampled at edge N, while the line is released, gives `startPulse` = 1 for exactly the one cycle after edge N+2, and `startLevel` = 1 from edge N+2.
- R6: Once set, `startLevel` stays 1 while `cascadeEn` is 1, even if `startIn` falls or more symbol pairs arrive.
- R7: Dropping `cascadeEn` sets `readyOe` to 1 in the same cycle, without waiting for a clock. The next edge clears `startLevel` and the captured symbol pair, so release after re-enabling needs a new pulse.
- R8: `startIn` being high before release, or staying high across release, starts nothing. Only a rising edge seen after release counts.
- R9: With several devices sharing a wired-AND line, the line stays low until the last device releases, and all devices then pulse `startPulse` on the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cascadeEn | input | 1 | Cascade-mode enable bit |
| jkPairSeen | input | 1 | Single-cycle pulse: J-K symbol pair received |
| startIn | input | 1 | Shared start line (asynchronous) |
| readyOe | output | 1 | 1 = drive the open-drain ready line low, 0 = release it |
| startPulse | output | 1 | One-cycle pulse when the start is granted |
| startLevel | output | 1 | Start granted, held until cascade mode is cleared |

## Verification
Release is due one edge after the edge that samples the symbol pair. The start pulse and level are due two edges after the edge that samples a rising start line: one for the second synchroniser flop and one for the state register. The `readyOe` response to clearing cascade mode is due within the same cycle. The bench applies inputs just after a rising edge and reads outputs one time unit after the next edge. It lays out each vector row, and each directed step, so that it samples on exactly those edges. Quiet stretches are checked on every cycle to show that nothing arrives early or by mistake.

// File: rtl/csync_pkg.sv
package csync_pkg;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_WAIT_JK  = 2'd1,
    ST_RELEASED = 2'd2,
    ST_STARTED  = 2'd3
  } csState_e;

  typedef struct packed {
    logic clrAll;
    logic markStart;
  } csStrobe_t;

endpackage

// File: rtl/csync_datapath.sv
module csync_datapath
  import csync_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      cascadeEn,
  input  logic      jkPairSeen,
  input  logic      startIn,
  input  csStrobe_t strobe,
  output logic      jkHeld,
  output logic      startRise,
  output logic      startPulse,
  output logic      startLevel
);

  localparam int CHAIN = SYNC_STAGES + 1;

  logic [CHAIN-1:0] syncQ;
  logic             jkQ;
  logic             pulseQ;
  logic             levelQ;

  // Synchroniser chain plus one extra stage used for edge detection
  genvar gi;
  generate
    for (gi = 0; gi < CHAIN; gi++) begin : g_sync
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[0] <= 1'b0;
          else       syncQ[0] <= startIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[gi] <= 1'b0;
          else       syncQ[gi] <= syncQ[gi-1];
        end
      end
    end
  endgenerate

  assign startRise = syncQ[SYNC_STAGES-1] & ~syncQ[SYNC_STAGES];

  // Sticky capture of the symbol pair
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              jkQ <= 1'b0;
    else if (strobe.clrAll) jkQ <= 1'b0;
    else if (jkPairSeen)    jkQ <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseQ <= 1'b0;
      levelQ <= 1'b0;
    end else begin
      pulseQ <= strobe.markStart;
      if (strobe.clrAll)         levelQ <= 1'b0;
      else if (strobe.markStart) levelQ <= 1'b1;
    end
  end

  assign jkHeld     = jkQ;
  assign startPulse = pulseQ;
  assign startLevel = levelQ;

  // R5: the start pulse lasts a single cycle
  a_r5_pulse_single: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> !startPulse);

  // R6: the level holds while cascade mode stays on
  a_r6_level_holds: assert property (@(posedge clk) disable iff (!rstN)
    (startLevel && cascadeEn) |=> startLevel);

  // R7: clearing cascade mode wipes the level and the captured pair
  a_r7_clear_on_disable: assert property (@(posedge clk) disable iff (!rstN)
    !cascadeEn |=> (!startLevel && !jkHeld));

endmodule

// File: rtl/csync_ctrl.sv
module csync_ctrl
  import csync_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cascadeEn,
  input  logic      jkHeld,
  input  logic      startRise,
  output csStrobe_t strobe,
  output logic      lineFree
);

  csState_e state, stateNext;

  always_comb begin
    stateNext = state;
    if (!cascadeEn) begin
      stateNext = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE:     stateNext = ST_WAIT_JK;
        ST_WAIT_JK:  if (jkHeld)    stateNext = ST_RELEASED;
        ST_RELEASED: if (startRise) stateNext = ST_STARTED;
        ST_STARTED:  stateNext = ST_STARTED;
        default:     stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobe.clrAll    = !cascadeEn;
    strobe.markStart = cascadeEn && (state == ST_RELEASED) && startRise;
  end

  assign lineFree = (state == ST_RELEASED) || (state == ST_STARTED);

  // R3: no release without a captured symbol pair
  a_r3_release_needs_jk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT_JK && !jkHeld) |=> state != ST_RELEASED);

  // R8: the started state is entered only on a seen rising edge
  a_r8_start_only_on_rise: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RELEASED && !startRise) |=> state != ST_STARTED);

endmodule

// File: rtl/cascade_sync.sv
module cascade_sync
  import csync_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic cascadeEn,
  input  logic jkPairSeen,
  input  logic startIn,
  output logic readyOe,
  output logic startPulse,
  output logic startLevel
);

  csStrobe_t strobe;
  logic      jkHeld;
  logic      startRise;
  logic      lineFree;

  csync_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cascadeEn (cascadeEn),
    .jkHeld    (jkHeld),
    .startRise (startRise),
    .strobe    (strobe),
    .lineFree  (lineFree)
  );

  csync_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .cascadeEn  (cascadeEn),
    .jkPairSeen (jkPairSeen),
    .startIn    (startIn),
    .strobe     (strobe),
    .jkHeld     (jkHeld),
    .startRise  (startRise),
    .startPulse (startPulse),
    .startLevel (startLevel)
  );

  // Releasing only while enabled lets a disable pull the line low at once
  assign readyOe = ~(lineFree & cascadeEn);

  // R4: a start is granted only after this device released the line
  a_r4_start_needs_release: assert property (@(posedge clk) disable iff (!rstN)
    $rose(startLevel) |-> $past(!readyOe));

  // R3: a released line implies a captured symbol pair
  a_r3_released_has_jk: assert property (@(posedge clk) disable iff (!rstN)
    !readyOe |-> jkHeld);

endmodule

// File: tb/cascade_sync_bench.sv
module cascade_sync_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic en0 = 1'b0, jk0 = 1'b0;
  logic en1 = 1'b0, jk1 = 1'b0;
  logic en2 = 1'b0, jk2 = 1'b0;
  logic useForce = 1'b0, forceVal = 1'b0;
  logic oe0, oe1, oe2, p0, p1, p2, l0, l1, l2;
  logic sharedLine, mainStart;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  assign sharedLine = ~(oe0 | oe1 | oe2);
  assign mainStart  = useForce ? forceVal : sharedLine;

  cascade_sync u_cascade_sync (
    .clk(clk), .rstN(rstN), .cascadeEn(en0), .jkPairSeen(jk0),
    .startIn(mainStart), .readyOe(oe0), .startPulse(p0), .startLevel(l0));

  cascade_sync u_peer1 (
    .clk(clk), .rstN(rstN), .cascadeEn(en1), .jkPairSeen(jk1),
    .startIn(sharedLine), .readyOe(oe1), .startPulse(p1), .startLevel(l1));

  cascade_sync u_peer2 (
    .clk(clk), .rstN(rstN), .cascadeEn(en2), .jkPairSeen(jk2),
    .startIn(sharedLine), .readyOe(oe2), .startPulse(p2), .startLevel(l2));

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // Each row is one cycle: {en, jk, expOe, expPulse, expLevel}
  localparam int NROWS = 20;
  localparam logic [4:0] VEC [NROWS] = '{
    5'b00_100, // 0  R1 idle
    5'b01_100, // 1  R2 pair while disabled
    5'b10_100, // 2  enable
    5'b10_100, // 3  R2 earlier pair forgotten
    5'b11_100, // 4  pair sampled
    5'b10_000, // 5  R3 released
    5'b10_000, // 6
    5'b10_000, // 7
    5'b10_011, // 8  R5 pulse
    5'b10_001, // 9  R5 pulse gone, level held
    5'b11_001, // 10 R6 extra pair ignored
    5'b00_100, // 11 R7 cleared
    5'b10_100, // 12 R7 re-enabled, no pair yet
    5'b10_100, // 13
    5'b11_100, // 14 new pair
    5'b10_000, // 15 R7 released again
    5'b10_000, // 16
    5'b10_000, // 17
    5'b10_011, // 18 R5
    5'b10_001  // 19 R6
  };

  initial begin
    #(4 * 200000);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int pulses;
    // R1: reset state
    #1;
    chk("R1 oe in reset", oe0, 1'b1);
    chk("R1 pulse in reset", p0, 1'b0);
    chk("R1 level in reset", l0, 1'b0);
    tick(); tick();
    rstN = 1'b1;
    tick();
    chk("R1 oe after reset", oe0, 1'b1);
    chk("R1 level after reset", l0, 1'b0);

    // Peers released ahead of the table
    en1 = 1; en2 = 1; jk1 = 1; jk2 = 1;
    tick();
    jk1 = 0; jk2 = 0;
    tick();
    chk("R3 peer1 released", oe1, 1'b0);

    for (int i = 0; i < NROWS; i++) begin
      en0 = VEC[i][4];
      jk0 = VEC[i][3];
      tick();
      chk($sformatf("R2/R3/R5/R6/R7 row %0d oe", i), oe0, VEC[i][2]);
      chk($sformatf("R5 row %0d pulse", i), p0, VEC[i][1]);
      chk($sformatf("R6/R7 row %0d level", i), l0, VEC[i][0]);
    end
    jk0 = 0;

    // R7: readyOe responds to disable within the cycle
    en0 = 0;
    #1;
    chk("R7 oe immediate", oe0, 1'b1);
    tick();

    // R4: sticky pair, start tied low never starts
    useForce = 1; forceVal = 0;
    en0 = 1; tick();
    jk0 = 1; tick();
    jk0 = 0; tick();
    chk("R4 released after single pulse", oe0, 1'b0);
    pulses = 0;
    for (int k = 0; k < 10; k++) begin
      tick();
      if (p0 || l0) pulses++;
    end
    chk("R4 tied low no start", pulses != 0, 1'b0);

    // R8: start high before and across release
    en0 = 0; tick();
    en0 = 1; forceVal = 1; tick();
    for (int k = 0; k < 5; k++) tick();
    chk("R8 no start while waiting", l0, 1'b0);
    jk0 = 1; tick();
    jk0 = 0; tick();
    chk("R8 released", oe0, 1'b0);
    pulses = 0;
    for (int k = 0; k < 5; k++) begin
      tick();
      if (p0 || l0) pulses++;
    end
    chk("R8 level across release no start", pulses != 0, 1'b0);
    forceVal = 0; tick(); tick(); tick();
    forceVal = 1;
    tick(); tick();
    chk("R5 not early", p0, 1'b0);
    tick();
    chk("R5 pulse on time", p0, 1'b1);
    chk("R5 level on time", l0, 1'b1);
    tick();
    chk("R5 pulse one cycle", p0, 1'b0);
    forceVal = 0;
    for (int k = 0; k < 4; k++) tick();
    chk("R6 level after start falls", l0, 1'b1);

    // R9: three devices on the wired-AND line
    useForce = 0;
    en0 = 0; en1 = 0; en2 = 0; tick();
    en0 = 1; en1 = 1; en2 = 1; tick();
    jk1 = 1; tick(); jk1 = 0; tick();
    chk("R9 peer1 released", oe1, 1'b0);
    chk("R9 line low with two holding", sharedLine, 1'b0);
    jk2 = 1; tick(); jk2 = 0; tick();
    chk("R9 line low with one holding", sharedLine, 1'b0);
    jk0 = 1; tick(); jk0 = 0; tick();
    chk("R9 line high when all free", sharedLine, 1'b1);
    tick(); tick();
    chk("R9 no early pulse", p0 | p1 | p2, 1'b0);
    tick();
    chk("R9 main pulse", p0, 1'b1);
    chk("R9 peer1 pulse same cycle", p1, 1'b1);
    chk("R9 peer2 pulse same cycle", p2, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule